// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Queue

This block sits between a 32-bit instruction fetch port and a decode stage. The instruction set mixes 16-bit and 32-bit encodings. The block requests one aligned 32-bit word per clock from its own sequential prefetch address counter. It keeps a small circular queue of those words. From the queue it cuts out whole instructions: a single halfword, or two halfwords that may sit in two different words. It hands them to decode one per clock over a valid/ready handshake, with a length flag and the address of each instruction.

A redirect from the branch logic empties the queue in the cycle it is raised. In that same cycle the fetch port is pointed at the word that holds the target, so the first target word can land right away. A target that starts in the upper halfword of a word makes the queue drop the lower halfword of the first word it takes in. The queue depth is a parameter and must be a power of two: 4 words for the full build, 2 for the reduced one. The length test is a mask/match comparison on the leading halfword, and both values are parameters.

Top module: `ibuf_prefetch`

## Requirements
- R1: After reset, out_valid is 0, fetch_req is 1, and both fetch_addr and out_pc equal RESET_ADDR (default 0).
- R2: fetch_addr always has bits [1:0] equal to zero. Each accepted fetch (fetch_req and fetch_ack high together) moves the next fetch address up by 4, unless a redirect is raised.
- R3: fetch_req goes low while the queue holds DEPTH words, counted from the word that holds the next instruction. The queue never holds more than DEPTH words.
- R4: An instruction is 32 bits long when its leading halfword ANDed with LONG_MASK equals LONG_MATCH (defaults 16'h8000 / 16'h8000, so bit 15 set), and 16 bits long otherwise. out_is_long reports the result.
- R5: Within a fetch word, bits [15:0] are the halfword at the lower address. out_instr[15:0] is the leading halfword. For a 32-bit instruction, out_instr[31:16] is the following halfword. For a 16-bit instruction, out_instr[31:16] is zero.
- R6: A 32-bit instruction whose second halfword has not yet arrived is not presented: out_valid stays low until both halves are in the queue.
- R7: Each instruction's out_pc equals the previous instruction's address plus 2 (16-bit) or plus 4 (32-bit).
- R8: While out_valid is high and out_ready is low, out_instr, out_is_long and out_pc hold unchanged on the next cycle unless a redirect is raised.
- R9: In a cycle with redirect_valid high, out_valid is 0, fetch_req is 1 and fetch_addr is the target with bits [1:0] cleared. All earlier queue contents are discarded.
- R10: If the redirect target has bit 1 set, the lower halfword of the first word fetched after it is discarded. In every case the first instruction issued after a redirect has out_pc equal to the target.
- R11: A word accepted in one cycle can be issued from the next cycle on, and at most one instruction is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | Branch redirect strobe; flushes the queue |
| redirect_addr | input | AW | Redirect target, halfword aligned |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | AW | Word-aligned fetch address |
| fetch_ack | input | 1 | Fetch accepted; fetch_data valid in the same cycle |
| fetch_data | input | 32 | Fetched word, lower halfword first in address order |
| out_valid | output | 1 | Instruction available to decode |
| out_ready | input | 1 | Decode accepts the instruction |
| out_instr | output | 32 | Instruction bits, leading halfword in [15:0] |
| out_is_long | output | 1 | 1 for a 32-bit instruction |
| out_pc | output | AW | Address of the presented instruction |

## Verification
fetch_req and fetch_addr are combinational in the current state and in redirect_valid, so they are checked in the same cycle the stimulus is applied. A word accepted at a clock edge, and the program-counter step after a handshake, show up on the out_* ports right after that edge. This is R11, the one-cycle delay. The bench drives every input just after a falling edge and samples 1 ns later. Its reference model is updated as though the coming rising edge had happened, so each expectation is compared one cycle after the stimulus that caused it. Hold behaviour under a stall compares the values seen in the previous cycle with those seen in the current one.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef logic [15:0] half_t;
    typedef logic [31:0] word_t;

    // Length decision on the leading halfword of an instruction.
    function automatic logic hw_is_long(input half_t hw, input half_t mask, input half_t match);
        return (hw & mask) == match;
    endfunction

    // Halfword count consumed by one instruction.
    function automatic logic [1:0] halves_of(input logic is_long);
        return is_long ? 2'd2 : 2'd1;
    endfunction

    typedef struct packed {
        word_t bits;
        logic  is_long;
    } instr_t;

endpackage

// File: rtl/ibuf_fetch_ctl.sv
module ibuf_fetch_ctl
    import ibuf_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redirect_valid,
    input  logic [AW-1:0] redirect_word,
    input  logic          slot_free,
    input  logic          fetch_ack,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          wr_en
);
    localparam logic [AW-1:0] RST_WORD = {RESET_ADDR[AW-1:2], 2'b00};

    logic [AW-1:0] pf_addr;

    assign fetch_req  = redirect_valid | slot_free;
    assign fetch_addr = redirect_valid ? redirect_word : pf_addr;
    assign wr_en      = fetch_req & fetch_ack;

    always_ff @(posedge clk) begin
        if (rst)
            pf_addr <= RST_WORD;
        else if (wr_en)
            pf_addr <= fetch_addr + AW'(4);
        else if (redirect_valid)
            pf_addr <= redirect_word;
    end

    assert_fetch_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_addr[1:0] == 2'b00));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (redirect_valid || fetch_addr == $past(fetch_addr) + AW'(4)));

endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
#(
    parameter int   DEPTH     = 4,
    parameter logic RESET_ODD = 1'b0,
    parameter int   CW        = $clog2(2*DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          flush_odd,
    input  logic          wr_en,
    input  word_t         wr_data,
    input  logic          pop,
    input  logic          pop_long,
    output half_t         head0,
    output half_t         head1,
    output logic [CW-1:0] hw_avail,
    output logic          slot_free
);
    localparam int PW       = $clog2(DEPTH);
    localparam int RPW      = PW + 1;
    localparam int HW_SLOTS = 2 * DEPTH;

    word_t          words [DEPTH];
    half_t          halves [HW_SLOTS];
    logic [PW-1:0]  wr_ptr;
    logic [RPW-1:0] rd_ptr;
    logic           skip_low;

    // Halfword view of the word array: even slot = lower address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_split
        assign halves[2*g]   = words[g][15:0];
        assign halves[2*g+1] = words[g][31:16];
    end

    assign head0 = halves[rd_ptr];
    assign head1 = halves[rd_ptr + RPW'(1)];

    logic [CW:0] span_hw;
    assign span_hw   = {1'b0, hw_avail} + (CW+1)'(rd_ptr[0]);
    assign slot_free = (span_hw >> 1) < (CW+1)'(DEPTH);

    logic [CW-1:0]  add_hw, sub_hw;
    logic [RPW-1:0] rd_step;
    assign add_hw  = wr_en ? (skip_low ? CW'(1) : CW'(2)) : CW'(0);
    assign sub_hw  = pop ? CW'(halves_of(pop_long)) : CW'(0);
    assign rd_step = pop ? RPW'(halves_of(pop_long)) : RPW'(0);

    always_ff @(posedge clk) begin
        if (wr_en && !rst)
            words[flush ? PW'(0) : wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= RPW'(RESET_ODD);
            hw_avail <= '0;
            skip_low <= RESET_ODD;
        end else if (flush) begin
            wr_ptr   <= wr_en ? PW'(1) : PW'(0);
            rd_ptr   <= RPW'(flush_odd);
            hw_avail <= wr_en ? (flush_odd ? CW'(1) : CW'(2)) : CW'(0);
            skip_low <= flush_odd & ~wr_en;
        end else begin
            wr_ptr   <= wr_ptr + PW'(wr_en);
            rd_ptr   <= rd_ptr + rd_step;
            hw_avail <= hw_avail + add_hw - sub_hw;
            if (wr_en)
                skip_low <= 1'b0;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        span_hw <= (CW+1)'(HW_SLOTS));

    assert_pop_complete_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (hw_avail >= CW'(halves_of(pop_long))));

endmodule

// File: rtl/ibuf_issue.sv
module ibuf_issue
    import ibuf_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          CW         = 4,
    parameter logic [31:0] RESET_ADDR = 32'h0,
    parameter half_t       LONG_MASK  = 16'h8000,
    parameter half_t       LONG_MATCH = 16'h8000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  half_t         head0,
    input  half_t         head1,
    input  logic [CW-1:0] hw_avail,
    input  logic          out_ready,
    output logic          out_valid,
    output word_t         out_instr,
    output logic          out_is_long,
    output logic [AW-1:0] out_pc,
    output logic          pop,
    output logic          pop_long
);
    instr_t        cur;
    logic          enough;
    logic [AW-1:0] pc_q;

    always_comb begin
        cur.is_long = hw_is_long(head0, LONG_MASK, LONG_MATCH);
        cur.bits    = cur.is_long ? {head1, head0} : {16'h0000, head0};
        enough      = cur.is_long ? (hw_avail >= CW'(2)) : (hw_avail >= CW'(1));
    end

    assign out_valid   = ~flush & enough;
    assign out_instr   = cur.bits;
    assign out_is_long = cur.is_long;
    assign out_pc      = pc_q;
    assign pop         = out_valid & out_ready;
    assign pop_long    = cur.is_long;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_ADDR[AW-1:0];
        else if (flush)
            pc_q <= flush_addr;
        else if (pop)
            pc_q <= pc_q + (cur.is_long ? AW'(4) : AW'(2));
    end

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> (out_pc == $past(out_pc) + ($past(out_is_long) ? AW'(4) : AW'(2))));

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (flush || (out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_is_long))));

    assert_redirect_pc_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_pc == $past(flush_addr)));

endmodule

// File: rtl/ibuf_prefetch.sv
module ibuf_prefetch
    import ibuf_pkg::*;
#(
    parameter int          DEPTH      = 4,
    parameter int          AW         = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0,
    parameter logic [15:0] LONG_MASK  = 16'h8000,
    parameter logic [15:0] LONG_MATCH = 16'h8000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redirect_valid,
    input  logic [AW-1:0] redirect_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_ack,
    input  logic [31:0]   fetch_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_instr,
    output logic          out_is_long,
    output logic [AW-1:0] out_pc
);
    localparam int CW = $clog2(2*DEPTH+1);

    logic [AW-1:0] redirect_word;
    logic          slot_free, wr_en, pop, pop_long;
    half_t         head0, head1;
    logic [CW-1:0] hw_avail;

    assign redirect_word = {redirect_addr[AW-1:2], 2'b00};

    ibuf_fetch_ctl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk(clk), .rst(rst),
        .redirect_valid(redirect_valid), .redirect_word(redirect_word),
        .slot_free(slot_free), .fetch_ack(fetch_ack),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .wr_en(wr_en)
    );

    ibuf_store #(.DEPTH(DEPTH), .RESET_ODD(RESET_ADDR[1]), .CW(CW)) u_store (
        .clk(clk), .rst(rst),
        .flush(redirect_valid), .flush_odd(redirect_addr[1]),
        .wr_en(wr_en), .wr_data(fetch_data),
        .pop(pop), .pop_long(pop_long),
        .head0(head0), .head1(head1), .hw_avail(hw_avail), .slot_free(slot_free)
    );

    ibuf_issue #(
        .AW(AW), .CW(CW), .RESET_ADDR(RESET_ADDR),
        .LONG_MASK(LONG_MASK), .LONG_MATCH(LONG_MATCH)
    ) u_issue (
        .clk(clk), .rst(rst),
        .flush(redirect_valid), .flush_addr(redirect_addr),
        .head0(head0), .head1(head1), .hw_avail(hw_avail),
        .out_ready(out_ready),
        .out_valid(out_valid), .out_instr(out_instr), .out_is_long(out_is_long),
        .out_pc(out_pc), .pop(pop), .pop_long(pop_long)
    );

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (!out_valid && fetch_req && fetch_addr == redirect_word));

endmodule

// File: tb/ibuf_prefetch_tb.sv
`timescale 1ns/100ps
module ibuf_prefetch_tb;
    localparam int DEPTH  = 4;
    localparam int AW     = 32;
    localparam int CYCLES = 8000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          redirect_valid = 1'b0;
    logic [AW-1:0] redirect_addr  = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_ack = 1'b0;
    logic [31:0]   fetch_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [31:0]   out_instr;
    logic          out_is_long;
    logic [AW-1:0] out_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] mem_hw(input logic [31:0] a);
        logic [31:0] x;
        x = (a >> 1) * 32'h9E3779B1;
        return x[28:13];
    endfunction

    assign fetch_data = {mem_hw(fetch_addr + 32'd2), mem_hw(fetch_addr)};

    ibuf_prefetch #(.DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_is_long(out_is_long), .out_pc(out_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc, fend, tgt, used_w, avail, exp_instr;
        logic [31:0] prev_instr, prev_pc;
        logic [15:0] h0;
        bit lng, exp_valid, exp_req, redir, ack, rdy, prev_stall, after_redir;
        int ack_pct, rdy_pct, redir_pct;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
        chk(fetch_req == 1'b1, "R1", "fetch_req after reset", 32'(fetch_req), 32'd1);
        chk(fetch_addr == 32'h0, "R1", "fetch_addr after reset", fetch_addr, 32'h0);
        chk(out_pc == 32'h0, "R1", "out_pc after reset", out_pc, 32'h0);

        exp_pc = 0; fend = 0; prev_stall = 0; after_redir = 0;
        prev_instr = 0; prev_pc = 0;
        ack_pct = 100; rdy_pct = 100; redir_pct = 0;

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            if (cyc % 250 == 0) begin
                case (cyc / 250)
                    0: begin ack_pct = 100; rdy_pct = 100; redir_pct = 0;  end // throughput
                    1: begin ack_pct = 100; rdy_pct = 0;   redir_pct = 0;  end // fill (R3)
                    2: begin ack_pct = 100; rdy_pct = 100; redir_pct = 15; end // redirects
                    3: begin ack_pct = 30;  rdy_pct = 100; redir_pct = 5;  end // starved: straddles
                    default: begin
                        case ($urandom % 4)
                            0: ack_pct = 100; 1: ack_pct = 85; 2: ack_pct = 50; default: ack_pct = 20;
                        endcase
                        case ($urandom % 4)
                            0: rdy_pct = 100; 1: rdy_pct = 70; 2: rdy_pct = 35; default: rdy_pct = 0;
                        endcase
                        case ($urandom % 4)
                            0: redir_pct = 0; 1: redir_pct = 2; 2: redir_pct = 5; default: redir_pct = 12;
                        endcase
                    end
                endcase
            end
            redir = ($urandom % 100) < redir_pct;
            ack   = ($urandom % 100) < ack_pct;
            rdy   = ($urandom % 100) < rdy_pct;
            tgt   = $urandom & 32'h0000_FFFE;
            redirect_valid = redir;
            redirect_addr  = tgt;
            fetch_ack      = ack;
            out_ready      = rdy;
            #1;

            used_w = (fend - (exp_pc & ~32'h3)) >> 2;
            avail  = (fend > exp_pc) ? ((fend - exp_pc) >> 1) : 32'd0;
            h0     = mem_hw(exp_pc);
            lng    = h0[15];
            exp_instr = lng ? {mem_hw(exp_pc + 32'd2), h0} : {16'h0000, h0};

            if (redir) begin
                exp_req = 1'b1; exp_valid = 1'b0;
                chk(fetch_req == 1'b1, "R9", "fetch_req on redirect", 32'(fetch_req), 32'd1);
                chk(fetch_addr == (tgt & ~32'h3), "R9", "fetch_addr on redirect", fetch_addr, tgt & ~32'h3);
                chk(out_valid == 1'b0, "R9", "out_valid on redirect", 32'(out_valid), 32'd0);
            end else begin
                exp_req   = used_w < DEPTH;
                exp_valid = (avail >= 1) && (!lng || avail >= 2);
                chk(fetch_req == exp_req, (used_w >= DEPTH) ? "R3" : "R2", "fetch_req",
                    32'(fetch_req), 32'(exp_req));
                if (exp_req)
                    chk(fetch_addr == fend, "R2", "fetch_addr", fetch_addr, fend);
                chk(out_valid == exp_valid, (lng && avail == 1) ? "R6" : "R11", "out_valid",
                    32'(out_valid), 32'(exp_valid));
                if (exp_valid) begin
                    chk(out_pc == exp_pc, after_redir ? "R10" : "R7", "out_pc", out_pc, exp_pc);
                    chk(out_is_long == lng, "R4", "out_is_long", 32'(out_is_long), 32'(lng));
                    chk(out_instr == exp_instr, "R5", "out_instr", out_instr, exp_instr);
                end
                if (prev_stall) begin
                    chk(out_instr == prev_instr, "R8", "held out_instr", out_instr, prev_instr);
                    chk(out_pc == prev_pc, "R8", "held out_pc", out_pc, prev_pc);
                end
            end

            prev_stall = exp_valid && !rdy;
            prev_instr = out_instr;
            prev_pc    = out_pc;
            if (redir) begin
                exp_pc = tgt;
                fend   = (tgt & ~32'h3) + (ack ? 32'd4 : 32'd0);
                after_redir = 1'b1;
            end else begin
                if (exp_req && ack)
                    fend = fend + 32'd4;
                if (exp_valid && rdy) begin
                    exp_pc = exp_pc + (lng ? 32'd4 : 32'd2);
                    after_redir = 1'b0;
                end
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule